// File: doc/BRIEF.md
# External Bus Access Sequencer

This block turns a single internal request into one timed access on an external memory or peripheral bus. Each access passes through a lead phase, an active phase and a trail phase, in that order. The length of each phase comes from a timing set chosen by the request's address zone. Every zone holds separate lead, active and trail fields for reads and for writes. A per-zone doubling bit multiplies the programmed lead, active and trail counts by two. A per-zone use-ready bit lets the external ready input stretch the active phase with wait states.

Chip select is high for every lead, active and trail cycle. The read or write strobe is high only in the active phase. Address and write data are held for the whole access, and the write data enable covers lead through trail. At the end of the final active cycle the block captures the read data. One cycle after trail it gives the requester a one-cycle done pulse. A request is accepted only while the sequencer is idle. The zone timing is sampled when the request is accepted. The block does not check for illegal settings: whatever is programmed is executed.

Top module: `xbus_access_seq`

## Requirements
- R1: Chip select is high through lead, active and trail. The read strobe (for reads) or the write strobe (for writes) is high only in the active phase. The two strobes are never high together, and chip select never drops between the lead and the trail of one access.
- R2: The lead phase lasts LEAD cycles, or 2×LEAD with the zone's doubling bit set. A lead value of 0 skips the phase, even with ready ignored, where it is an illegal setting that is still executed as programmed.
- R3: The active phase lasts ACTIVE+1+WS cycles, or 2×ACTIVE+1+WS with doubling set. The WS term and the +1 are never doubled.
- R4: The trail phase lasts TRAIL cycles, or 2×TRAIL with doubling set. A value of 0 skips the phase.
- R5: The fields come from the requested zone's timing set. The read fields apply when req_wr_i=0 and the write fields when req_wr_i=1. Field k of a flattened config port occupies bits [k*W +: W].
- R6: With the zone's use-ready bit set, ready_i is sampled only at the end of the final base active cycle. Each low sample adds one active cycle. Ready in any other cycle has no effect.
- R7: With the use-ready bit clear, ready_i is ignored and WS is 0.
- R8: For a read, rdata_o holds the bus data present in the last active cycle, and is valid from the done pulse until the next read ends.
- R9: addr_o and wdata_o hold the request's values for the whole access. data_oe_o is high from the first lead cycle to the last trail cycle of a write, and is never high during a read.
- R10: done_o is a one-cycle pulse in the cycle after the last trail cycle (or the last active cycle when trail is skipped). req_ready_o is high only when idle, and a request presented while busy is ignored.
- R11: After reset, chip select, both strobes, data_oe_o and done_o are low and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request is taken this cycle |
| req_zone_i | input | ZW | Zone of the request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Request write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |
| cfg_rd_lead_i | input | NZONES*LEADW | Read lead count per zone |
| cfg_rd_act_i | input | NZONES*ACTW | Read active count per zone |
| cfg_rd_trail_i | input | NZONES*TRAILW | Read trail count per zone |
| cfg_wr_lead_i | input | NZONES*LEADW | Write lead count per zone |
| cfg_wr_act_i | input | NZONES*ACTW | Write active count per zone |
| cfg_wr_trail_i | input | NZONES*TRAILW | Write trail count per zone |
| cfg_dbl_i | input | NZONES | Per-zone phase doubling |
| cfg_use_rdy_i | input | NZONES | Per-zone ready sampling enable |
| ready_i | input | 1 | External ready |
| bus_rdata_i | input | DW | External read data |
| cs_o | output | 1 | Chip select |
| rd_stb_o | output | 1 | Read strobe |
| wr_stb_o | output | 1 | Write strobe |
| addr_o | output | AW | Bus address |
| wdata_o | output | DW | Bus write data |
| data_oe_o | output | 1 | Write data drive enable |

## Verification
A request is taken at the clock edge where it is presented while idle. Chip select rises one cycle later. From there, lead, active and trail fill the next L, A+WS and T cycles, and done_o comes in the cycle right after. The bench drives inputs on the falling edge and samples once per cycle at the falling edge. It counts each phase from the outputs and compares the counts with lengths computed from the fields. Ready is driven on the falling edge inside each active cycle so that it is seen at the edge that closes that cycle. The bus read data expected for a read is the value the bench drove during the last cycle in which it saw the strobe high.

// File: rtl/xbs_pkg.sv
// Package: shared state encoding for the bus access sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package xbs_pkg;

    // Sequencer phases; DONE is the one-cycle completion slot.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_ACT   = 3'd2,
        ST_TRAIL = 3'd3,
        ST_DONE  = 3'd4
    } xbs_state_e;

    // Scaled lead/trail length: field shifted left once when doubling.
    function automatic logic [15:0] xbs_scale(input logic [15:0] f, input logic dbl);
        return dbl ? (f << 1) : f;
    endfunction

endpackage

// File: rtl/xbs_zone_sel.sv
// Module: picks the timing fields of one zone and one direction and turns
// them into phase lengths in clock cycles (doubling applied, +1 on active).
// Assumes: NZONES is a power of two so the zone index covers the table exactly;
// counter width CW holds 2*max(field)+1.
module xbs_zone_sel
    import xbs_pkg::*;
#(
    parameter int NZONES = 4,
    parameter int LEADW  = 2,
    parameter int ACTW   = 2,
    parameter int TRAILW = 2,
    parameter int CW     = 4,
    localparam int ZW    = (NZONES > 1) ? $clog2(NZONES) : 1
) (
    input  logic [ZW-1:0]            zone_i,
    input  logic                     wr_i,
    input  logic [NZONES*LEADW-1:0]  rd_lead_i,
    input  logic [NZONES*ACTW-1:0]   rd_act_i,
    input  logic [NZONES*TRAILW-1:0] rd_trail_i,
    input  logic [NZONES*LEADW-1:0]  wr_lead_i,
    input  logic [NZONES*ACTW-1:0]   wr_act_i,
    input  logic [NZONES*TRAILW-1:0] wr_trail_i,
    input  logic [NZONES-1:0]        dbl_i,
    input  logic [NZONES-1:0]        use_rdy_i,
    output logic [CW-1:0]            lead_len_o,
    output logic [CW-1:0]            act_len_o,
    output logic [CW-1:0]            trail_len_o,
    output logic                     use_rdy_o
);

    logic [LEADW-1:0]  rl_a [NZONES];
    logic [ACTW-1:0]   ra_a [NZONES];
    logic [TRAILW-1:0] rt_a [NZONES];
    logic [LEADW-1:0]  wl_a [NZONES];
    logic [ACTW-1:0]   wa_a [NZONES];
    logic [TRAILW-1:0] wt_a [NZONES];

    // Unpack the flattened per-zone field vectors into tables.
    for (genvar z = 0; z < NZONES; z++) begin : g_unpack
        assign rl_a[z] = rd_lead_i[z*LEADW +: LEADW];
        assign ra_a[z] = rd_act_i[z*ACTW +: ACTW];
        assign rt_a[z] = rd_trail_i[z*TRAILW +: TRAILW];
        assign wl_a[z] = wr_lead_i[z*LEADW +: LEADW];
        assign wa_a[z] = wr_act_i[z*ACTW +: ACTW];
        assign wt_a[z] = wr_trail_i[z*TRAILW +: TRAILW];
    end

    logic [LEADW-1:0]  sel_lead;
    logic [ACTW-1:0]   sel_act;
    logic [TRAILW-1:0] sel_trail;
    logic              sel_dbl;
    logic [15:0]       lead_sc;
    logic [15:0]       act_sc;
    logic [15:0]       trail_sc;

    // Direction and zone selection of the raw fields.
    always_comb begin
        sel_lead  = wr_i ? wl_a[zone_i] : rl_a[zone_i];
        sel_act   = wr_i ? wa_a[zone_i] : ra_a[zone_i];
        sel_trail = wr_i ? wt_a[zone_i] : rt_a[zone_i];
        sel_dbl   = dbl_i[zone_i];
        use_rdy_o = use_rdy_i[zone_i];
    end

    // Scale to cycle counts; only the programmed part of active is doubled.
    always_comb begin
        lead_sc     = xbs_scale(16'(sel_lead), sel_dbl);
        act_sc      = xbs_scale(16'(sel_act), sel_dbl) + 16'd1;
        trail_sc    = xbs_scale(16'(sel_trail), sel_dbl);
        lead_len_o  = lead_sc[CW-1:0];
        act_len_o   = act_sc[CW-1:0];
        trail_len_o = trail_sc[CW-1:0];
    end

endmodule

// File: rtl/xbs_phase_ctl.sv
// Module: phase state machine with one down-counter reloaded per phase.
// Lead and trail of length 0 are skipped; active is always at least one
// cycle and is stretched by one cycle per low ready sample taken in its
// final base cycle when ready use is enabled.
// Assumes: lengths are valid in the cycle start_i is high; they are latched.
module xbs_phase_ctl
    import xbs_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] lead_len_i,
    input  logic [CW-1:0] act_len_i,
    input  logic [CW-1:0] trail_len_i,
    input  logic          use_rdy_i,
    input  logic          ready_i,
    output logic          idle_o,
    output logic          busy_o,
    output logic          act_o,
    output logic          act_end_o,
    output logic          done_o
);

    xbs_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] act_q;
    logic [CW-1:0] trail_q;
    logic          rdy_q;
    logic          last_base;
    logic          wait_now;

    // Final base active cycle and the wait-state condition in it.
    always_comb begin
        last_base = (state_q == ST_ACT) && (cnt_q == '0);
        wait_now  = last_base && rdy_q && !ready_i;
        act_end_o = last_base && !wait_now;
    end

    // Phase sequencing and per-phase counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            act_q   <= '0;
            trail_q <= '0;
            rdy_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        act_q   <= act_len_i;
                        trail_q <= trail_len_i;
                        rdy_q   <= use_rdy_i;
                        if (lead_len_i != '0) begin
                            state_q <= ST_LEAD;
                            cnt_q   <= lead_len_i - CW'(1);
                        end else begin
                            state_q <= ST_ACT;
                            cnt_q   <= act_len_i - CW'(1);
                        end
                    end
                end
                ST_LEAD: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_ACT;
                        cnt_q   <= act_q - CW'(1);
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                ST_ACT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CW'(1);
                    end else if (!wait_now) begin
                        if (trail_q != '0) begin
                            state_q <= ST_TRAIL;
                            cnt_q   <= trail_q - CW'(1);
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (cnt_q == '0) state_q <= ST_DONE;
                    else             cnt_q   <= cnt_q - CW'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Phase decode to control outputs.
    always_comb begin
        idle_o = (state_q == ST_IDLE);
        busy_o = (state_q == ST_LEAD) || (state_q == ST_ACT) || (state_q == ST_TRAIL);
        act_o  = (state_q == ST_ACT);
        done_o = (state_q == ST_DONE);
    end

    a_r6_wait_holds_active: assert property (@(posedge clk) disable iff (!rst_n)
        wait_now |=> (state_q == ST_ACT) && (cnt_q == '0));
    a_r2_lead_leads_to_active: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) |=> (state_q == ST_LEAD) || (state_q == ST_ACT));
    a_r4_trail_leads_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIL) |=> (state_q == ST_TRAIL) || (state_q == ST_DONE));

endmodule

// File: rtl/xbs_bus_if.sv
// Module: holds the request's address, data and direction for the access,
// drives the bus strobes and captures read data at the end of active.
// Assumes: start_i only in idle; act_end_i marks the last active cycle.
module xbs_bus_if #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          busy_i,
    input  logic          act_i,
    input  logic          act_end_i,
    input  logic [DW-1:0] bus_rdata_i,
    output logic          cs_o,
    output logic          rd_stb_o,
    output logic          wr_stb_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          data_oe_o,
    output logic [DW-1:0] rdata_o
);

    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;

    // Latch request fields when the access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start_i) begin
            wr_q    <= wr_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end
    end

    // Capture bus read data at the close of the last active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (act_end_i && !wr_q) rdata_q <= bus_rdata_i;
    end

    // Bus-side decode of the phase and direction.
    always_comb begin
        cs_o      = busy_i;
        rd_stb_o  = act_i && !wr_q;
        wr_stb_o  = act_i && wr_q;
        data_oe_o = busy_i && wr_q;
        addr_o    = addr_q;
        wdata_o   = wdata_q;
        rdata_o   = rdata_q;
    end

    a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb_o && wr_stb_o));
    a_r1_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_o || wr_stb_o) |-> cs_o);
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o && $past(cs_o)) |-> ($stable(addr_o) && $stable(wdata_o)));
    a_r9_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> !rd_stb_o);

endmodule

// File: rtl/xbus_access_seq.sv
// Module: top of the external bus access sequencer. Accepts one request
// when idle, selects the zone timing, sequences lead/active/trail and
// reports completion with a one-cycle done pulse.
// Assumes: configuration is static in the cycle a request is accepted;
// illegal timing values are executed as programmed.
module xbus_access_seq #(
    parameter int NZONES = 4,
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int LEADW  = 2,
    parameter int ACTW   = 2,
    parameter int TRAILW = 2,
    localparam int ZW    = (NZONES > 1) ? $clog2(NZONES) : 1,
    localparam int MAXW  = (LEADW > ACTW) ? ((LEADW > TRAILW) ? LEADW : TRAILW)
                                          : ((ACTW > TRAILW) ? ACTW : TRAILW),
    localparam int CW    = MAXW + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid_i,
    output logic                     req_ready_o,
    input  logic [ZW-1:0]            req_zone_i,
    input  logic                     req_wr_i,
    input  logic [AW-1:0]            req_addr_i,
    input  logic [DW-1:0]            req_wdata_i,
    output logic                     done_o,
    output logic [DW-1:0]            rdata_o,
    input  logic [NZONES*LEADW-1:0]  cfg_rd_lead_i,
    input  logic [NZONES*ACTW-1:0]   cfg_rd_act_i,
    input  logic [NZONES*TRAILW-1:0] cfg_rd_trail_i,
    input  logic [NZONES*LEADW-1:0]  cfg_wr_lead_i,
    input  logic [NZONES*ACTW-1:0]   cfg_wr_act_i,
    input  logic [NZONES*TRAILW-1:0] cfg_wr_trail_i,
    input  logic [NZONES-1:0]        cfg_dbl_i,
    input  logic [NZONES-1:0]        cfg_use_rdy_i,
    input  logic                     ready_i,
    input  logic [DW-1:0]            bus_rdata_i,
    output logic                     cs_o,
    output logic                     rd_stb_o,
    output logic                     wr_stb_o,
    output logic [AW-1:0]            addr_o,
    output logic [DW-1:0]            wdata_o,
    output logic                     data_oe_o
);

    logic [CW-1:0] lead_len;
    logic [CW-1:0] act_len;
    logic [CW-1:0] trail_len;
    logic          use_rdy;
    logic          idle;
    logic          busy;
    logic          act;
    logic          act_end;
    logic          start;

    // Acceptance only while idle.
    always_comb begin
        req_ready_o = idle;
        start       = idle && req_valid_i;
    end

    xbs_zone_sel #(
        .NZONES(NZONES), .LEADW(LEADW), .ACTW(ACTW), .TRAILW(TRAILW), .CW(CW)
    ) u_zone_sel (
        .zone_i     (req_zone_i),
        .wr_i       (req_wr_i),
        .rd_lead_i  (cfg_rd_lead_i),
        .rd_act_i   (cfg_rd_act_i),
        .rd_trail_i (cfg_rd_trail_i),
        .wr_lead_i  (cfg_wr_lead_i),
        .wr_act_i   (cfg_wr_act_i),
        .wr_trail_i (cfg_wr_trail_i),
        .dbl_i      (cfg_dbl_i),
        .use_rdy_i  (cfg_use_rdy_i),
        .lead_len_o (lead_len),
        .act_len_o  (act_len),
        .trail_len_o(trail_len),
        .use_rdy_o  (use_rdy)
    );

    xbs_phase_ctl #(.CW(CW)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .lead_len_i (lead_len),
        .act_len_i  (act_len),
        .trail_len_i(trail_len),
        .use_rdy_i  (use_rdy),
        .ready_i    (ready_i),
        .idle_o     (idle),
        .busy_o     (busy),
        .act_o      (act),
        .act_end_o  (act_end),
        .done_o     (done_o)
    );

    xbs_bus_if #(.AW(AW), .DW(DW)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .wr_i       (req_wr_i),
        .addr_i     (req_addr_i),
        .wdata_i    (req_wdata_i),
        .busy_i     (busy),
        .act_i      (act),
        .act_end_i  (act_end),
        .bus_rdata_i(bus_rdata_i),
        .cs_o       (cs_o),
        .rd_stb_o   (rd_stb_o),
        .wr_stb_o   (wr_stb_o),
        .addr_o     (addr_o),
        .wdata_o    (wdata_o),
        .data_oe_o  (data_oe_o),
        .rdata_o    (rdata_o)
    );

    a_r10_done_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(cs_o));
    a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_accept_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_o) |-> $past(req_ready_o && req_valid_i));

endmodule

// File: tb/xbus_access_seq_tb.sv
// Bench: sweeps every lead/active/trail value of a 2-bit field, both
// directions, both doubling settings, ready use on and off and 0..2 wait
// states, comparing phase lengths and bus values to computed ones.
module xbus_access_seq_tb;

    localparam int NZ = 4;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int FW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_zone = '0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          done;
    logic [DW-1:0] rdata;
    logic [NZ*FW-1:0] rl = '0, ra = '0, rt = '0, wl = '0, wa = '0, wt = '0;
    logic [NZ-1:0] dbl = '0, urdy = '0;
    logic          ready = 1'b1;
    logic [DW-1:0] bus_rdata = '0;
    logic          cs, rd_stb, wr_stb, data_oe;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    xbus_access_seq #(.NZONES(NZ), .AW(AW), .DW(DW), .LEADW(FW), .ACTW(FW), .TRAILW(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_zone_i(req_zone), .req_wr_i(req_wr), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .done_o(done), .rdata_o(rdata),
        .cfg_rd_lead_i(rl), .cfg_rd_act_i(ra), .cfg_rd_trail_i(rt),
        .cfg_wr_lead_i(wl), .cfg_wr_act_i(wa), .cfg_wr_trail_i(wt),
        .cfg_dbl_i(dbl), .cfg_use_rdy_i(urdy), .ready_i(ready), .bus_rdata_i(bus_rdata),
        .cs_o(cs), .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .addr_o(addr), .wdata_o(wdata),
        .data_oe_o(data_oe)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Run one access on zone z with the given fields, k low ready samples.
    task automatic run_access(input int z, input bit w, input int fl, input int fa, input int ft,
                              input bit d, input bit u, input int k, input int seed);
        int exp_l, exp_a, exp_t, n_l, n_a, n_t, given, guard;
        bit seen_act, bad_stb, bad_bus, bad_rdy, got_done;
        logic [DW-1:0] exp_rd;
        logic [AW-1:0] a_val;
        logic [DW-1:0] d_val;
        // Fill every zone and both directions; non-target fields differ (R5).
        for (int q = 0; q < NZ; q++) begin
            rl[q*FW +: FW] = FW'(fl + q + 1); ra[q*FW +: FW] = FW'(fa + q + 2);
            rt[q*FW +: FW] = FW'(ft + q + 1); wl[q*FW +: FW] = FW'(fl + q + 2);
            wa[q*FW +: FW] = FW'(fa + q + 1); wt[q*FW +: FW] = FW'(ft + q + 3);
            dbl[q] = ~d; urdy[q] = ~u;
        end
        if (w) begin
            wl[z*FW +: FW] = FW'(fl); wa[z*FW +: FW] = FW'(fa); wt[z*FW +: FW] = FW'(ft);
        end else begin
            rl[z*FW +: FW] = FW'(fl); ra[z*FW +: FW] = FW'(fa); rt[z*FW +: FW] = FW'(ft);
        end
        dbl[z] = d; urdy[z] = u;
        exp_l = d ? 2*fl : fl;
        exp_a = (d ? 2*fa : fa) + 1 + (u ? k : 0);
        exp_t = d ? 2*ft : ft;
        a_val = AW'(seed * 97 + 13);
        d_val = DW'(seed * 53 + 7);
        chk(req_ready === 1'b1, "R10 ready when idle", int'(req_ready), 1);
        req_valid = 1'b1; req_zone = 2'(z); req_wr = w; req_addr = a_val; req_wdata = d_val;
        ready = 1'b0;
        n_l = 0; n_a = 0; n_t = 0; given = 0; guard = 0;
        seen_act = 0; bad_stb = 0; bad_bus = 0; bad_rdy = 0; got_done = 0; exp_rd = '0;
        @(negedge clk);
        // Busy: present a conflicting request that must be ignored (R10).
        req_zone = 2'(z + 1); req_wr = ~w; req_addr = ~a_val; req_wdata = ~d_val;
        while (!got_done && guard < 100) begin
            guard++;
            bus_rdata = DW'(seed * 31 + guard * 7 + 3);
            if (done) begin
                got_done = 1;
                req_valid = 1'b0;
            end else begin
                if (req_ready) bad_rdy = 1;
                if (!cs) bad_stb = 1;
                if ((rd_stb && w) || (wr_stb && !w)) bad_stb = 1;
                if (addr !== a_val || data_oe !== w || (w && wdata !== d_val)) bad_bus = 1;
                if (rd_stb || wr_stb) begin
                    seen_act = 1; n_a++;
                    exp_rd = bus_rdata;
                    if (n_a < ((d ? 2*fa : fa) + 1)) ready = 1'b0;
                    else if (given < k) begin ready = 1'b0; given++; end
                    else ready = 1'b1;
                end else begin
                    ready = 1'b0;
                    if (seen_act) n_t++; else n_l++;
                end
                @(negedge clk);
            end
        end
        chk(got_done, "R10 done reached (watchdog)", int'(got_done), 1);
        chk(n_l == exp_l, "R2 R5 lead cycles", n_l, exp_l);
        chk(n_a == exp_a, u ? "R3 R6 active cycles" : "R3 R7 active cycles", n_a, exp_a);
        chk(n_t == exp_t, "R4 R5 trail cycles", n_t, exp_t);
        chk(!bad_stb, "R1 cs/strobe framing", int'(bad_stb), 0);
        chk(!bad_bus, "R9 addr/wdata/oe held", int'(bad_bus), 0);
        chk(!bad_rdy, "R10 no accept while busy", int'(bad_rdy), 0);
        if (!w) chk(rdata === exp_rd, "R8 read capture", int'(rdata), int'(exp_rd));
        @(negedge clk);
        chk(!done && !cs && req_ready, "R10 single done then idle", int'(done), 0);
    endtask

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the ports.
        chk(!cs && !rd_stb && !wr_stb && !data_oe && !done, "R11 outputs low", int'(cs), 0);
        chk(req_ready === 1'b1, "R11 ready high", int'(req_ready), 1);
        idx = 0;
        for (int fl = 0; fl < 4; fl++)
            for (int fa = 0; fa < 4; fa++)
                for (int ft = 0; ft < 4; ft++)
                    for (int d = 0; d < 2; d++)
                        for (int w = 0; w < 2; w++) begin
                            run_access(idx % NZ, w[0], fl, fa, ft, d[0],
                                       ((idx / 3) % 2) == 0, idx % 3, idx);
                            idx++;
                        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule